// File: doc/BRIEF.md
# Systolic FIR Filter

This block is a sample-by-sample finite impulse response filter with a fixed set of real coefficients. Its structure is a direct-form systolic chain. Every tap is a registered multiply followed by a registered add into a partial sum, and that partial sum moves one tap per step. The input samples travel down a delay line that holds two registers per tap, so each sample meets its partial sum at the right tap. A new signed fixed-point sample can be accepted on every clock.

Coefficients are given at a wide source precision as an elaboration parameter. They are reduced to the multiplier width with round-to-nearest and clamping. The full-precision sum is right-shifted to the output scale, using either round-to-nearest or floor as chosen by a parameter. It is then clamped or wrapped to the output width.

The whole pipeline steps only on cycles that carry a valid sample. Idle cycles therefore leave every partial sum intact, and a small shift register of valid flags marks when the chain holds real history.

Top module: `fir_systolic`

## Requirements
- R1: While `rst` is high at a clock edge, all pipeline and flag registers clear. On the following cycle `out_valid` is 0 and `out_sample` is 0.
- R2: Let x(0), x(1), … be the accepted samples. The result for sample m is y(m) = Σ q_j·x(m−j) over taps j = 0..L−1, where x(k) = 0 for k < 0 and q_j is the quantized coefficient of tap j. This sum is then reduced as in R7 to R10.
- R3: A sample enters the filter only on a clock edge where `in_valid` is 1. The value on `in_sample` in any other cycle has no effect on later outputs.
- R4: When the sample with index n (counted from 0 since reset) is accepted, `out_valid` is 1 on the next cycle if n ≥ L+2, and `out_sample` then carries y(n−L−2). In every other cycle `out_valid` is 0.
- R5: `out_sample` keeps its value on every cycle that follows an edge with no accepted sample.
- R6: Tap j's coefficient is the signed COEF_SRC_W-bit field at bit offset j·COEF_SRC_W of `COEF_SRC`. It is narrowed to COEF_W bits as floor((raw + 2^(D−1)) / 2^D), where D = COEF_SRC_W − COEF_W, and then clamped to the signed COEF_W range.
- R7: When ROUND is nearest, the output scale value is floor((acc + 2^(OUT_SHIFT−1)) / 2^OUT_SHIFT).
- R8: When ROUND is floor, the output scale value is floor(acc / 2^OUT_SHIFT).
- R9: When SATURATE is 1, a scaled value outside the signed OUT_W range becomes −2^(OUT_W−1) or 2^(OUT_W−1)−1.
- R10: When SATURATE is 0, `out_sample` is the low OUT_W bits of the scaled value.
- R11: When `in_valid` is held high, the block produces one result per clock once L+2 samples have been accepted.
- R12: The accumulator has DATA_W + COEF_W + ceil(log2 L) bits. A sum of L full-scale products of the same sign therefore reaches the output stage without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks `in_sample` as a sample to accept |
| in_sample | input | DATA_W | Signed input sample |
| out_valid | output | 1 | One-cycle flag that a new result is present |
| out_sample | output | OUT_W | Signed, rounded and limited filter result |

## Verification
The assertions assume that `in_valid` is always a known 0 or 1. They also assume that reset is held for at least one full cycle before the first sample. Under those assumptions, the accepted-sample count they keep matches the filter's own notion of how full it is. The stimulus drives `in_valid` only with explicit 0/1 values and holds reset for several cycles at the start and again in the middle of the run. It also drives `in_valid` high while reset is asserted, so that reset is seen to take priority.

// File: rtl/fir_pkg.sv
package fir_pkg;

   // Rounding applied when the accumulator is scaled to the output.
   typedef enum logic [0:0] {
      RND_FLOOR   = 1'b0,
      RND_NEAREST = 1'b1
   } fir_round_e;

   // Extra accumulator bits needed to add n products without wrap.
   function automatic int guard_bits(input int n);
      return (n <= 1) ? 0 : $clog2(n);
   endfunction

endpackage

// File: rtl/fir_coef_quant.sv
module fir_coef_quant #(
   parameter int                        NTAPS      = 8,
   parameter int                        SRC_W      = 20,
   parameter int                        COEF_W     = 16,
   parameter logic [NTAPS*SRC_W-1:0]    COEF_SRC   = '0
) (
   output logic [NTAPS*COEF_W-1:0]      coef_flat
);

   localparam int DROP = SRC_W - COEF_W;

   if (DROP < 0) begin : g_bad_width
      $error("fir_coef_quant: COEF_W must not exceed SRC_W");
   end

   for (genvar i = 0; i < NTAPS; i++) begin : g_tap
      localparam logic signed [SRC_W-1:0] RAW = COEF_SRC[i*SRC_W +: SRC_W];

      if (DROP == 0) begin : g_pass
         assign coef_flat[i*COEF_W +: COEF_W] = RAW;
      end else begin : g_round
         localparam logic signed [SRC_W:0] HALF =
            {{(SRC_W+1-DROP){1'b0}}, 1'b1, {(DROP-1){1'b0}}};
         localparam logic signed [SRC_W:0] RND  = $signed({RAW[SRC_W-1], RAW}) + HALF;
         localparam logic signed [SRC_W:0] SHF  = RND >>> DROP;
         localparam logic signed [SRC_W:0] CMAX =
            {{(DROP+1){1'b0}}, 1'b0, {(COEF_W-1){1'b1}}};
         localparam logic signed [SRC_W:0] CMIN =
            {{(DROP+1){1'b1}}, 1'b1, {(COEF_W-1){1'b0}}};
         localparam logic signed [SRC_W:0] LIM  =
            (SHF > CMAX) ? CMAX : ((SHF < CMIN) ? CMIN : SHF);
         assign coef_flat[i*COEF_W +: COEF_W] = LIM[COEF_W-1:0];
      end
   end

endmodule

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
   parameter int NTAPS  = 8,
   parameter int DATA_W = 16
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        en,
   input  logic signed [DATA_W-1:0]    din,
   output logic [NTAPS*DATA_W-1:0]     taps
);

   // a_q[i] feeds the multiplier of tap i; b_q[i] is the extra stage
   // that delays a sample by one more step before the next tap.
   logic signed [DATA_W-1:0] a_q [NTAPS];
   logic signed [DATA_W-1:0] b_q [NTAPS-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NTAPS; i++)     a_q[i] <= '0;
         for (int i = 0; i < NTAPS - 1; i++) b_q[i] <= '0;
      end else if (en) begin
         a_q[0] <= din;
         for (int i = 1; i < NTAPS; i++)     a_q[i] <= b_q[i-1];
         for (int i = 0; i < NTAPS - 1; i++) b_q[i] <= a_q[i];
      end
   end

   for (genvar i = 0; i < NTAPS; i++) begin : g_out
      assign taps[i*DATA_W +: DATA_W] = a_q[i];
   end

endmodule

// File: rtl/fir_mac_tap.sv
module fir_mac_tap #(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int ACC_W  = 35
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       en,
   input  logic signed [DATA_W-1:0]   x,
   input  logic signed [COEF_W-1:0]   coef,
   input  logic signed [ACC_W-1:0]    sum_in,
   output logic signed [ACC_W-1:0]    sum_out
);

   localparam int PROD_W = DATA_W + COEF_W;

   logic signed [PROD_W-1:0] prod_q;
   logic signed [ACC_W-1:0]  prod_ext;
   logic signed [ACC_W-1:0]  sum_q;

   assign prod_ext = ACC_W'(prod_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         prod_q <= '0;
         sum_q  <= '0;
      end else if (en) begin
         prod_q <= PROD_W'(x) * PROD_W'(coef);
         sum_q  <= sum_in + prod_ext;
      end
   end

   assign sum_out = sum_q;

endmodule

// File: rtl/fir_out_quant.sv
module fir_out_quant
   import fir_pkg::*;
#(
   parameter int          ACC_W    = 35,
   parameter int          OUT_W    = 16,
   parameter int          SHIFT    = 15,
   parameter fir_round_e  ROUND    = RND_NEAREST,
   parameter bit          SATURATE = 1'b1
) (
   input  logic signed [ACC_W-1:0] acc,
   output logic signed [OUT_W-1:0] q
);

   localparam int RW = ACC_W + 1 - SHIFT;

   logic signed [ACC_W:0] acc_x;
   logic signed [ACC_W:0] rnd;

   assign acc_x = {acc[ACC_W-1], acc};

   if (ROUND == RND_NEAREST) begin : g_nearest
      localparam logic signed [ACC_W:0] HALF =
         {{(ACC_W+1-SHIFT){1'b0}}, 1'b1, {(SHIFT-1){1'b0}}};
      assign rnd = acc_x + HALF;
   end else begin : g_floor
      assign rnd = acc_x;
   end

   if (SATURATE) begin : g_sat
      logic signed [RW-1:0] sh;
      logic                 fits;
      assign sh   = RW'(rnd >>> SHIFT);
      assign fits = (sh[RW-1:OUT_W-1] == {(RW-OUT_W+1){sh[RW-1]}});
      assign q    = fits       ? sh[OUT_W-1:0] :
                    sh[RW-1]   ? {1'b1, {(OUT_W-1){1'b0}}} :
                                 {1'b0, {(OUT_W-1){1'b1}}};
   end else begin : g_wrap
      assign q = OUT_W'(rnd >>> SHIFT);
   end

endmodule

// File: rtl/fir_valid_track.sv
module fir_valid_track #(
   parameter int DEPTH = 10
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   output logic out_valid
);

   // fill_q[k] becomes 1 once more than k samples have been accepted.
   logic [DEPTH-1:0] fill_q;
   logic             valid_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         fill_q  <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= en & fill_q[DEPTH-1];
         if (en) fill_q <= {fill_q[DEPTH-2:0], 1'b1};
      end
   end

   assign out_valid = valid_q;

endmodule

// File: rtl/fir_systolic.sv
module fir_systolic
   import fir_pkg::*;
#(
   parameter int                             NTAPS      = 8,
   parameter int                             DATA_W     = 16,
   parameter int                             COEF_SRC_W = 20,
   parameter int                             COEF_W     = 16,
   parameter int                             OUT_W      = 16,
   parameter int                             OUT_SHIFT  = 15,
   parameter fir_round_e                     ROUND      = RND_NEAREST,
   parameter bit                             SATURATE   = 1'b1,
   parameter logic [NTAPS*COEF_SRC_W-1:0]    COEF_SRC   =
      {20'h01000, 20'h03000, 20'h06000, 20'h08000,
       20'h08000, 20'h06000, 20'h03000, 20'h01000}
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic signed [DATA_W-1:0]   in_sample,
   output logic                       out_valid,
   output logic signed [OUT_W-1:0]    out_sample
);

   localparam int GUARD  = guard_bits(NTAPS);
   localparam int PROD_W = DATA_W + COEF_W;
   localparam int ACC_W  = PROD_W + GUARD;
   localparam int FILL   = NTAPS + 2;

   if (NTAPS < 2) begin : g_bad_taps
      $error("fir_systolic: NTAPS must be at least 2");
   end
   if (OUT_SHIFT < 1 || OUT_SHIFT >= ACC_W) begin : g_bad_shift
      $error("fir_systolic: OUT_SHIFT must lie in 1..ACC_W-1");
   end
   if (ACC_W + 1 - OUT_SHIFT < OUT_W) begin : g_bad_out
      $error("fir_systolic: OUT_W wider than the scaled accumulator");
   end

   logic [NTAPS*COEF_W-1:0]  coef_flat;
   logic [NTAPS*DATA_W-1:0]  tap_x;
   logic signed [ACC_W-1:0]  sum_chain [NTAPS+1];
   logic signed [OUT_W-1:0]  q_next;
   logic signed [OUT_W-1:0]  out_q;

   fir_coef_quant #(
      .NTAPS    (NTAPS),
      .SRC_W    (COEF_SRC_W),
      .COEF_W   (COEF_W),
      .COEF_SRC (COEF_SRC)
   ) u_coef (
      .coef_flat (coef_flat)
   );

   fir_delay_line #(
      .NTAPS  (NTAPS),
      .DATA_W (DATA_W)
   ) u_line (
      .clk  (clk),
      .rst  (rst),
      .en   (in_valid),
      .din  (in_sample),
      .taps (tap_x)
   );

   assign sum_chain[0] = '0;

   for (genvar i = 0; i < NTAPS; i++) begin : g_mac
      fir_mac_tap #(
         .DATA_W (DATA_W),
         .COEF_W (COEF_W),
         .ACC_W  (ACC_W)
      ) u_tap (
         .clk     (clk),
         .rst     (rst),
         .en      (in_valid),
         .x       (tap_x[i*DATA_W +: DATA_W]),
         .coef    (coef_flat[i*COEF_W +: COEF_W]),
         .sum_in  (sum_chain[i]),
         .sum_out (sum_chain[i+1])
      );
   end

   fir_out_quant #(
      .ACC_W    (ACC_W),
      .OUT_W    (OUT_W),
      .SHIFT    (OUT_SHIFT),
      .ROUND    (ROUND),
      .SATURATE (SATURATE)
   ) u_quant (
      .acc (sum_chain[NTAPS]),
      .q   (q_next)
   );

   always_ff @(posedge clk) begin
      if (rst)           out_q <= '0;
      else if (in_valid) out_q <= q_next;
   end

   fir_valid_track #(
      .DEPTH (FILL)
   ) u_vtrk (
      .clk       (clk),
      .rst       (rst),
      .en        (in_valid),
      .out_valid (out_valid)
   );

   assign out_sample = out_q;

endmodule

// File: rtl/fir_systolic_chk.sv
module fir_systolic_chk #(
   parameter int NTAPS = 8,
   parameter int OUT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             out_valid,
   input logic [OUT_W-1:0] out_sample
);

   localparam int CW  = $clog2(NTAPS + 4) + 1;
   localparam int SAT = NTAPS + 3;

   // Accepted samples since reset, held once it reaches SAT.
   logic [CW-1:0] seen_q;

   always_ff @(posedge clk) begin
      if (rst)                                      seen_q <= '0;
      else if (in_valid && seen_q < CW'(SAT))       seen_q <= seen_q + 1'b1;
   end

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && out_sample == '0));

   assert_valid_after_accept_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid));

   assert_no_early_valid_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (seen_q > CW'(NTAPS + 2)));

   assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(in_valid) && !$past(rst)) |-> $stable(out_sample));

   assert_full_rate_R11: assert property (@(posedge clk) disable iff (rst)
      (in_valid && seen_q >= CW'(NTAPS + 2)) |=> out_valid);

endmodule

bind fir_systolic fir_systolic_chk #(
   .NTAPS (NTAPS),
   .OUT_W (OUT_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .in_valid   (in_valid),
   .out_valid  (out_valid),
   .out_sample (out_sample)
);

// File: tb/fir_systolic_tb.sv
module fir_systolic_tb;

   localparam int NT  = 8;
   localparam int DW  = 16;
   localparam int SW  = 20;
   localparam int CWD = 16;
   localparam int OW  = 16;
   localparam int SH  = 15;
   localparam int WATCHDOG = 20000;

   localparam logic [NT*SW-1:0] TB_COEF =
      {20'sd7, 20'sd524032, -20'sd40000, 20'sd524272,
       -20'sd24, 20'sd24, 20'h80000, 20'h7FFFF};
   int raw [NT] = '{524287, -524288, 24, -24, 524272, -40000, 524032, 7};

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 in_valid = 1'b0;
   logic signed [DW-1:0] in_sample = '0;
   logic                 v0, v1;
   logic signed [OW-1:0] y0, y1;

   always #5 clk = ~clk;

   // Nearest rounding with clamping.
   fir_systolic #(
      .NTAPS(NT), .DATA_W(DW), .COEF_SRC_W(SW), .COEF_W(CWD), .OUT_W(OW),
      .OUT_SHIFT(SH), .ROUND(fir_pkg::RND_NEAREST), .SATURATE(1'b1),
      .COEF_SRC(TB_COEF)
   ) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(v0), .out_sample(y0)
   );

   // Floor rounding with wrap.
   fir_systolic #(
      .NTAPS(NT), .DATA_W(DW), .COEF_SRC_W(SW), .COEF_W(CWD), .OUT_W(OW),
      .OUT_SHIFT(SH), .ROUND(fir_pkg::RND_FLOOR), .SATURATE(1'b0),
      .COEF_SRC(TB_COEF)
   ) u_dut_wrap (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
      .out_valid(v1), .out_sample(y1)
   );

   int    checks = 0;
   int    errors = 0;
   int    cyc    = 0;
   int    qc [NT];
   int    hist [$];
   bit    exp_v   = 1'b0;
   int    exp_y0  = 0;
   int    exp_y1  = 0;
   string tag     = "R1";

   function automatic int coef_q(int r);
      int t;
      t = (r + 8) >>> 4;
      if (t > 32767)  t = 32767;
      if (t < -32768) t = -32768;
      return t;
   endfunction

   function automatic longint fir_sum(int n);
      longint s = 0;
      for (int j = 0; j < NT; j++) begin
         int idx = n - (NT + 2) - j;
         if (idx >= 0) s += longint'(qc[j]) * longint'(hist[idx]);
      end
      return s;
   endfunction

   function automatic int scale(longint acc, bit nearest, bit sat);
      longint r;
      logic [63:0] rb;
      r = nearest ? acc + (64'sd1 <<< (SH - 1)) : acc;
      r = r >>> SH;
      if (sat) begin
         if (r > 32767)  r = 32767;
         if (r < -32768) r = -32768;
         return int'(r);
      end
      rb = r;
      return int'($signed(rb[15:0]));
   endfunction

   task automatic check(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Compare the outputs of the last edge, then drive the next inputs
   // and advance the reference model to match the coming edge.
   task automatic cycle(bit r, bit v, int x);
      @(negedge clk);
      check("near_sat valid", int'(v0), int'(exp_v));
      check("near_sat data",  int'(y0), exp_y0);
      check("floor_wrap valid", int'(v1), int'(exp_v));
      check("floor_wrap data",  int'(y1), exp_y1);
      rst       = r;
      in_valid  = v;
      in_sample = DW'(x);
      if (r) begin
         hist.delete();
         exp_v  = 1'b0;
         exp_y0 = 0;
         exp_y1 = 0;
      end else if (v) begin
         longint acc;
         int n;
         hist.push_back(x);
         n      = hist.size() - 1;
         acc    = fir_sum(n);
         exp_v  = (n >= NT + 2);
         exp_y0 = scale(acc, 1'b1, 1'b1);
         exp_y1 = scale(acc, 1'b0, 1'b0);
      end else begin
         exp_v = 1'b0;
      end
   endtask

   function automatic int rnd_full();
      return int'($signed(16'($urandom)));
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > WATCHDOG) begin
         errors++;
         $display("FAIL R11 watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int j = 0; j < NT; j++) qc[j] = coef_q(raw[j]);

      // R1: reset state.
      tag = "R1";
      repeat (3) cycle(1'b1, 1'b0, 0);
      cycle(1'b0, 1'b0, 0);

      // R6 R9 R10: negative full-scale impulse shows each quantized
      // coefficient negated; tap 1 yields +32768, clamped or wrapped.
      tag = "R6 R9 R10";
      cycle(1'b0, 1'b1, -32768);
      repeat (2*NT + 4) cycle(1'b0, 1'b1, 0);

      // R7 R8: half-scale impulse gives coefficient/2, rounded per mode.
      tag = "R7 R8";
      cycle(1'b0, 1'b1, 16384);
      repeat (2*NT + 4) cycle(1'b0, 1'b1, 0);

      // R2 R11: back-to-back full-scale random samples.
      tag = "R2 R11";
      repeat (40) cycle(1'b0, 1'b1, rnd_full());

      // R12: samples chosen so every product is negative and large.
      tag = "R12";
      for (int j = NT - 1; j >= 0; j--)
         cycle(1'b0, 1'b1, (qc[j] >= 0) ? -32768 : 32767);
      repeat (2*NT + 4) cycle(1'b0, 1'b1, 0);

      // R3 R5: bubbles with junk data between accepted samples.
      tag = "R3 R5";
      for (int k = 0; k < 80; k++) begin
         if (($urandom % 10) < 4) cycle(1'b0, 1'b0, rnd_full());
         else cycle(1'b0, 1'b1, int'($urandom % 4001) - 2000);
      end

      // R1: reset in mid-stream with in_valid held high.
      tag = "R1";
      repeat (2) cycle(1'b1, 1'b1, 12345);
      cycle(1'b0, 1'b0, 0);

      // R4: refill after reset; no result until L+2 samples are in.
      tag = "R4";
      repeat (NT + 8) cycle(1'b0, 1'b1, rnd_full());
      cycle(1'b0, 1'b0, 0);
      cycle(1'b0, 1'b0, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule